// File: doc/BRIEF.md
# Address Window Chip-Select Decoder

This block compares each external bus address with four programmable address windows and falls back to a default region when none of them matches. It then drives one of five active-low chip selects. Each window is described by a base page and a size code. The block also latches the bus configuration word of the selected window, so that the bus cycle logic can read it through `selCfg`. Where windows overlap, a fixed order decides: window 4 wins over 3, window 3 over 2, and window 2 over 1. Window 0 is the default region.

The block can narrow the address space to 16 MB, 1 MB, 256 KB or 64 KB. Address bits above the chosen space read as zero. Decoding uses this masked address, and only the matching number of upper address lines reaches the segment output. The block samples the address at the rising edge of the address-latch strobe, seen on a rising clock edge. The chip selects then change either at that clock edge (early mode) or half a clock cycle later, on the following falling edge (the default timing).

Top module: `addr_window_cs_decoder`

## Requirements
- R1: Window w (1..4) matches when the masked address lies in a block of 2^(11+k) bytes whose base is `winBase[w-1]` times 4096, where k = `winSize[w-1]`. Base bits below the block size are ignored. A size code of 0, 14 or 15 disables the window, and code 13 covers the whole 16 MB space.
- R2: The selected index is the highest-numbered matching window (4 over 3 over 2 over 1). The index is 0 when no window matches.
- R3: During an external access exactly one chip select is low, and it is `csN[winIdx]`. Before the first captured access, all chip selects are high.
- R4: When `extBusEn` is 0 (single-chip mode) or `busReleased` is 1, all five chip selects are high at once, whatever was captured.
- R5: Address, window index, configuration and segment lines are captured only at a clock edge where `alatch` is high and was low at the previous edge. Otherwise they hold, even if the address changes.
- R6: With `csEarly`=1, `csN` takes its new value at the capturing rising edge. With `csEarly`=0, it keeps the old value until the next falling clock edge and then changes. `winIdx`, `selCfg` and `segAddr` always update at the capturing rising edge.
- R7: `spaceSel` 0/1/2/3 selects 16 MB/1 MB/256 KB/64 KB. `segAddr` carries address bits 23:16 with only the lowest 8/4/2/0 lines passed and the rest zero. Decoding uses the address with those upper bits cleared.
- R8: `selCfg` is the configuration word `winCfg[winIdx]`, taken at the capturing edge (index 0 being the default configuration).
- R9: After reset, `csN` is all ones, `winIdx` is 0, `segAddr` is 0 and `selCfg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | External bus address |
| alatch | input | 1 | Address-latch strobe; the rising edge starts an access |
| extBusEn | input | 1 | 1 = external bus mode, 0 = single-chip mode |
| busReleased | input | 1 | 1 while the bus is granted to another master |
| csEarly | input | 1 | 1 = chip selects change at the strobe edge, 0 = half a cycle later |
| spaceSel | input | 2 | Address space: 0=16 MB, 1=1 MB, 2=256 KB, 3=64 KB |
| winBase | input | 4x12 | Base page (address bits 23:12) of windows 1..4 |
| winSize | input | 4x4 | Size codes of windows 1..4 |
| winCfg | input | 5x8 | Bus configuration words; index 0 is the default region |
| csN | output | 5 | Active-low chip selects; bit i belongs to window i |
| winIdx | output | 3 | Index of the selected window |
| selCfg | output | 8 | Configuration word of the selected window |
| segAddr | output | 8 | Upper address lines, with undriven lines at zero |

## Verification
A wrong priority order or a wrong match mask shows up as a wrong `winIdx` and a misplaced low chip select, right after the capturing edge. Corrupt capture state shows as outputs that change while the strobe stays high, or that do not change on a new strobe. A wrong timing stage shows as a chip select that is already new, or still old, at the instant between the capturing rising edge and the following falling edge. Masking errors show at once as nonzero undriven segment lines, or as decoding into a window that the masked address cannot reach.

// File: rtl/cswd_pkg.sv
`timescale 1ns/1ps
package cswd_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capture;  // strobe rising edge seen at this clock edge
    logic busOff;   // chip selects must all be inactive
  } ctl_strobe_t;

  // Number of upper address lines driven for each address-space code
  function automatic int segLines(input logic [1:0] code, input int segW);
    case (code)
      2'd0:    segLines = segW;
      2'd1:    segLines = 4;
      2'd2:    segLines = 2;
      default: segLines = 0;
    endcase
  endfunction
endpackage

// File: rtl/cswd_window_match.sv
`timescale 1ns/1ps
module cswd_window_match #(
  parameter int PG_W   = 12,
  parameter int SIZE_W = 4
) (
  input  logic [PG_W-1:0]   pageAddr,
  input  logic [PG_W-1:0]   basePage,
  input  logic [SIZE_W-1:0] sizeCode,
  output logic              hit
);
  localparam int MAX_CODE = PG_W + 1;

  logic enabled;
  logic allEq;

  assign enabled = (sizeCode != '0) && (int'(sizeCode) <= MAX_CODE);

  // Page bit j takes part in the compare only if it lies at or above the window size
  always_comb begin
    allEq = 1'b1;
    for (int j = 0; j < PG_W; j++) begin
      if (((j + 1) >= int'(sizeCode)) && (pageAddr[j] != basePage[j])) allEq = 1'b0;
    end
  end

  assign hit = enabled && allEq;
endmodule

// File: rtl/cswd_ctrl.sv
`timescale 1ns/1ps
module cswd_ctrl
  import cswd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alatch,
  input  logic        extBusEn,
  input  logic        busReleased,
  output ctl_strobe_t strobes
);
  logic alatchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alatchPrev <= 1'b0;
    else       alatchPrev <= alatch;
  end

  always_comb begin
    strobes.capture = alatch && !alatchPrev;
    strobes.busOff  = !extBusEn || busReleased;
  end
endmodule

// File: rtl/cswd_datapath.sv
`timescale 1ns/1ps
module cswd_datapath
  import cswd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PAGE_SH = 12,
  parameter int SEG_LO  = 16,
  parameter int NUM_WIN = 4,
  parameter int SIZE_W  = 4,
  parameter int CFG_W   = 8,
  localparam int PG_W   = ADDR_W - PAGE_SH,
  localparam int SEG_W  = ADDR_W - SEG_LO,
  localparam int NUM_CS = NUM_WIN + 1,
  localparam int IDX_W  = $clog2(NUM_CS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctl_strobe_t                      strobes,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             csEarly,
  input  logic [1:0]                       spaceSel,
  input  logic [NUM_WIN-1:0][PG_W-1:0]     winBase,
  input  logic [NUM_WIN-1:0][SIZE_W-1:0]   winSize,
  input  logic [NUM_WIN:0][CFG_W-1:0]      winCfg,
  output logic [NUM_CS-1:0]                csN,
  output logic [IDX_W-1:0]                 winIdx,
  output logic [CFG_W-1:0]                 selCfg,
  output logic [SEG_W-1:0]                 segAddr
);
  logic [ADDR_W-1:0]  keepMask;
  logic [ADDR_W-1:0]  maskedAddr;
  logic [NUM_WIN-1:0] winHit;
  logic [IDX_W-1:0]   idxNext;
  logic [IDX_W-1:0]   idxQ;
  logic [CFG_W-1:0]   cfgQ;
  logic [SEG_W-1:0]   segQ;
  logic               validQ;
  logic [NUM_CS-1:0]  csEarlyVec;
  logic [NUM_CS-1:0]  csLateQ;
  logic [NUM_CS-1:0]  csRaw;

  // Address space restriction: bits above the driven lines read as zero
  always_comb begin
    int lines;
    lines = segLines(spaceSel, SEG_W);
    for (int b = 0; b < ADDR_W; b++) begin
      keepMask[b] = (b < SEG_LO) || ((b - SEG_LO) < lines);
    end
  end
  assign maskedAddr = addr & keepMask;

  // One comparator per window
  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    cswd_window_match #(
      .PG_W  (PG_W),
      .SIZE_W(SIZE_W)
    ) uMatch (
      .pageAddr(maskedAddr[ADDR_W-1:PAGE_SH]),
      .basePage(winBase[w]),
      .sizeCode(winSize[w]),
      .hit     (winHit[w])
    );
  end

  // Fixed order: a higher window number overrides a lower one
  always_comb begin
    idxNext = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (winHit[w]) idxNext = IDX_W'(w + 1);
    end
  end

  // Capture at the strobe edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      cfgQ   <= '0;
      segQ   <= '0;
      validQ <= 1'b0;
    end else if (strobes.capture) begin
      idxQ   <= idxNext;
      cfgQ   <= winCfg[idxNext];
      segQ   <= maskedAddr[ADDR_W-1:SEG_LO];
      validQ <= 1'b1;
    end
  end

  always_comb begin
    csEarlyVec = '1;
    if (validQ) csEarlyVec[idxQ] = 1'b0;
  end

  // Half-cycle delayed copy for the default chip-select timing
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) csLateQ <= '1;
    else       csLateQ <= csEarlyVec;
  end

  assign csRaw   = csEarly ? csEarlyVec : csLateQ;
  assign csN     = strobes.busOff ? '1 : csRaw;
  assign winIdx  = idxQ;
  assign selCfg  = cfgQ;
  assign segAddr = segQ;
endmodule

// File: rtl/addr_window_cs_decoder.sv
`timescale 1ns/1ps
module addr_window_cs_decoder
  import cswd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PAGE_SH = 12,
  parameter int SEG_LO  = 16,
  parameter int NUM_WIN = 4,
  parameter int SIZE_W  = 4,
  parameter int CFG_W   = 8,
  localparam int PG_W   = ADDR_W - PAGE_SH,
  localparam int SEG_W  = ADDR_W - SEG_LO,
  localparam int NUM_CS = NUM_WIN + 1,
  localparam int IDX_W  = $clog2(NUM_CS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           alatch,
  input  logic                           extBusEn,
  input  logic                           busReleased,
  input  logic                           csEarly,
  input  logic [1:0]                     spaceSel,
  input  logic [NUM_WIN-1:0][PG_W-1:0]   winBase,
  input  logic [NUM_WIN-1:0][SIZE_W-1:0] winSize,
  input  logic [NUM_WIN:0][CFG_W-1:0]    winCfg,
  output logic [NUM_CS-1:0]              csN,
  output logic [IDX_W-1:0]               winIdx,
  output logic [CFG_W-1:0]               selCfg,
  output logic [SEG_W-1:0]               segAddr
);
  ctl_strobe_t strobes;

  cswd_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .alatch     (alatch),
    .extBusEn   (extBusEn),
    .busReleased(busReleased),
    .strobes    (strobes)
  );

  cswd_datapath #(
    .ADDR_W (ADDR_W),
    .PAGE_SH(PAGE_SH),
    .SEG_LO (SEG_LO),
    .NUM_WIN(NUM_WIN),
    .SIZE_W (SIZE_W),
    .CFG_W  (CFG_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addr),
    .csEarly (csEarly),
    .spaceSel(spaceSel),
    .winBase (winBase),
    .winSize (winSize),
    .winCfg  (winCfg),
    .csN     (csN),
    .winIdx  (winIdx),
    .selCfg  (selCfg),
    .segAddr (segAddr)
  );
endmodule

// File: rtl/cswd_checker.sv
`timescale 1ns/1ps
module cswd_checker #(
  parameter int NUM_CS = 5,
  parameter int IDX_W  = 3,
  parameter int SEG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              alatch,
  input logic              extBusEn,
  input logic              busReleased,
  input logic [1:0]        spaceSel,
  input logic [NUM_CS-1:0] csN,
  input logic [IDX_W-1:0]  winIdx,
  input logic [SEG_W-1:0]  segAddr
);
  AST_CS_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (csN != '1) |-> (csN == ~(NUM_CS'(1) << winIdx))); // R3

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R3

  AST_BUS_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!extBusEn || busReleased) |-> (csN == '1)); // R4

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(alatch) |=> $stable(winIdx)); // R5

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(alatch) |=> $stable(segAddr)); // R5

  AST_SEG_64K_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alatch) && spaceSel == 2'd3) |=> (segAddr == '0)); // R7

  AST_SEG_1M_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alatch) && spaceSel == 2'd1) |=> (segAddr[SEG_W-1:4] == '0)); // R7

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(winIdx) < NUM_CS); // R2
endmodule

bind addr_window_cs_decoder cswd_checker #(
  .NUM_CS(NUM_CS),
  .IDX_W (IDX_W),
  .SEG_W (SEG_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .alatch     (alatch),
  .extBusEn   (extBusEn),
  .busReleased(busReleased),
  .spaceSel   (spaceSel),
  .csN        (csN),
  .winIdx     (winIdx),
  .segAddr    (segAddr)
);

// File: tb/sim_addr_window_cs_decoder.sv
`timescale 1ns/1ps
module sim_addr_window_cs_decoder;
  typedef struct packed {
    logic [23:0] a;
    logic [1:0]  ss;
    logic [2:0]  idx;
    logic [7:0]  seg;
  } vec_t;

  // Windows: W1 0x010000/64KB, W2 0x018000/16KB, W3 0x100000/1MB, W4 0x01A000/4KB
  localparam vec_t VECS [12] = '{
    '{24'h010004, 2'd0, 3'd1, 8'h01},  // R1 W1 only
    '{24'h019000, 2'd0, 3'd2, 8'h01},  // R2 W2 over W1
    '{24'h01A123, 2'd0, 3'd4, 8'h01},  // R2 W4 over W2
    '{24'h1FFFFF, 2'd0, 3'd3, 8'h1F},  // R1 top of W3
    '{24'h200000, 2'd0, 3'd0, 8'h20},  // R2 default
    '{24'h00FFFF, 2'd0, 3'd0, 8'h00},  // R1 just below W1
    '{24'h01C000, 2'd0, 3'd1, 8'h01},  // R1 just past W2
    '{24'h518000, 2'd0, 3'd0, 8'h51},  // R7 full space
    '{24'h518000, 2'd1, 3'd2, 8'h01},  // R7 1MB folds to W2
    '{24'h31A800, 2'd2, 3'd4, 8'h01},  // R7 256KB folds to W4
    '{24'h1A0500, 2'd3, 3'd0, 8'h00},  // R7 64KB
    '{24'h100000, 2'd0, 3'd3, 8'h10}   // R1 base of W3
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [23:0] addr = '0;
  logic alatch = 1'b0;
  logic extBusEn = 1'b1;
  logic busReleased = 1'b0;
  logic csEarly = 1'b1;
  logic [1:0] spaceSel = 2'd0;
  logic [3:0][11:0] winBase;
  logic [3:0][3:0]  winSize;
  logic [4:0][7:0]  winCfg;
  logic [4:0] csN;
  logic [2:0] winIdx;
  logic [7:0] selCfg;
  logic [7:0] segAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_window_cs_decoder u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .alatch(alatch), .extBusEn(extBusEn),
    .busReleased(busReleased), .csEarly(csEarly), .spaceSel(spaceSel),
    .winBase(winBase), .winSize(winSize), .winCfg(winCfg),
    .csN(csN), .winIdx(winIdx), .selCfg(selCfg), .segAddr(segAddr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] csFor(input int idx);
    csFor = ~(5'd1 << idx);
  endfunction

  // Strobe low for one cycle, then high with the new address; returns just after the capturing edge
  task automatic access(input logic [23:0] a, input logic [1:0] ss);
    @(negedge clk);
    alatch = 1'b0;
    @(negedge clk);
    addr = a;
    spaceSel = ss;
    alatch = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic checkAll(input string req, input int idx, input logic [7:0] seg);
    check({req, " csN"}, 32'(csN), 32'(csFor(idx)));
    check({req, " winIdx"}, 32'(winIdx), 32'(idx));
    check({req, " segAddr"}, 32'(segAddr), 32'(seg));
    check({req, " selCfg R8"}, 32'(selCfg), 32'(8'hA0 + idx));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    winBase = {12'h01A, 12'h100, 12'h018, 12'h010};
    winSize = {4'd1, 4'd9, 4'd3, 4'd5};
    for (int i = 0; i < 5; i++) winCfg[i] = 8'(8'hA0 + i);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 csN", 32'(csN), 32'h1F);
    check("R9 winIdx", 32'(winIdx), 0);
    check("R9 segAddr", 32'(segAddr), 0);
    check("R9 selCfg", 32'(selCfg), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 no access yet", 32'(csN), 32'h1F);

    // Vector table, early timing
    for (int v = 0; v < 12; v++) begin
      access(VECS[v].a, VECS[v].ss);
      checkAll("R1 R2 R7 vector", int'(VECS[v].idx), VECS[v].seg);
    end

    // R5: address changes with the strobe held high do nothing
    @(negedge clk);
    addr = 24'h019000;
    spaceSel = 2'd0;
    repeat (2) @(negedge clk);
    #2;
    check("R5 hold winIdx", 32'(winIdx), 3);
    check("R5 hold csN", 32'(csN), 32'(csFor(3)));
    check("R5 hold segAddr", 32'(segAddr), 32'h10);

    // R6 default timing: change waits for the falling edge
    @(negedge clk);
    csEarly = 1'b0;
    access(24'h010004, 2'd0);
    check("R6 late winIdx at rising edge", 32'(winIdx), 1);
    check("R6 late csN still old", 32'(csN), 32'(csFor(3)));
    @(negedge clk);
    #2;
    check("R6 late csN after falling edge", 32'(csN), 32'(csFor(1)));
    // R6 early timing
    @(negedge clk);
    csEarly = 1'b1;
    access(24'h200000, 2'd0);
    check("R6 early csN at rising edge", 32'(csN), 32'(csFor(0)));

    // R4 single-chip mode and released bus
    @(negedge clk);
    extBusEn = 1'b0;
    #2;
    check("R4 single-chip csN", 32'(csN), 32'h1F);
    access(24'h019000, 2'd0);
    check("R4 single-chip during access", 32'(csN), 32'h1F);
    @(negedge clk);
    extBusEn = 1'b1;
    #2;
    check("R4 restored csN", 32'(csN), 32'(csFor(2)));
    @(negedge clk);
    busReleased = 1'b1;
    #2;
    check("R4 released csN", 32'(csN), 32'h1F);
    @(negedge clk);
    busReleased = 1'b0;

    // R1 disabled codes 0 and 15 on W4, so W2 is selected
    winSize[3] = 4'd0;
    access(24'h01A123, 2'd0);
    checkAll("R1 size code 0 disabled", 2, 8'h01);
    winSize[3] = 4'd15;
    access(24'h01A123, 2'd0);
    checkAll("R1 size code 15 disabled", 2, 8'h01);
    winSize[3] = 4'd1;

    // R1 code 13 covers everything
    winSize[0] = 4'd13;
    access(24'h700000, 2'd0);
    checkAll("R1 code 13 full space", 1, 8'h70);
    winSize[0] = 4'd5;

    // R1 base bits below the size are ignored
    winBase[2] = 12'h1AB;
    access(24'h1F0000, 2'd0);
    checkAll("R1 unaligned base", 3, 8'h1F);
    winBase[2] = 12'h100;

    // R2 W4 inside W3
    winBase[3] = 12'h150;
    access(24'h150010, 2'd0);
    checkAll("R2 W4 over W3", 4, 8'h15);
    access(24'h151000, 2'd0);
    checkAll("R2 W3 beside W4", 3, 8'h15);

    // R8 configuration word change is taken at the next capture
    winCfg[3] = 8'h5C;
    access(24'h151000, 2'd0);
    check("R8 updated cfg", 32'(selCfg), 32'h5C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule